// File: doc/BRIEF.md
# Set-Associative Cache Lookup and Line Allocation

This block keeps the tag, the physical line address, the valid state and the data words of every line of a set-associative cache. The set, way and line-size counts are parameters. A lookup request compares the line-aligned address against every way of the indexed set and reports hit or miss. On a hit it also returns the way and the addressed data word. An allocate request picks a victim way in the indexed set and installs a new line there.

Each set has its own round-robin victim pointer. The pointer advances on every allocation into that set. A mode input selects write-back or write-through per allocation. In write-back mode a valid victim is first handed to an external eviction agent through a request/done handshake. The line is then refilled word by word from a simple read port. In write-through mode only the tag and the physical address are written, and the line is done in one cycle.

Top module: `sa_cache_ctrl`

## Requirements
- R1: A lookup (`req_alloc`=0) accepted while `req_ready` is high produces `rsp_valid` for exactly the next cycle. It has `rsp_hit`=1 when a valid line of set `req_va[OFF_W+SET_W-1:OFF_W]` holds tag `req_va[ADDR_W-1:OFF_W]`. `rsp_way` gives that way, and `rsp_data` gives its word number `req_va[OFF_W-1:2]`.
- R2: A lookup whose line address is held by no valid way of its set returns `rsp_hit`=0, including a line that was replaced by a later allocation.
- R3: An allocate (`req_alloc`=1) uses the victim way named by its set's pointer. Each set's pointer starts at 0, advances by one per allocation into that set only, and wraps from WAYS-1 to 0. The allocation response has `rsp_hit`=0 and `rsp_way` equal to the victim.
- R4: In write-back mode (`wb_mode`=1) with a valid victim, `evict_valid` rises before any read and carries the victim's set, way and stored line-aligned physical address. It stays high until `evict_done`, and no read is issued while it is high.
- R5: In write-back mode the refill issues LINE_BYTES/4 reads in rising word order, from the line-aligned `req_pa`. Each address is held until `mem_rd_ack`. The returned words are what later hits deliver.
- R6: In write-through mode (`wb_mode`=0) an allocation issues no read and no eviction. It responds in the next cycle with `req_ready` still high.
- R7: Synchronous reset invalidates every line and returns every set's pointer to 0. After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd_valid` and `evict_valid` are 0.
- R8: `req_ready` is low from the cycle after a write-back allocation is accepted until the cycle after its last refill word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1 = write-back allocation, 0 = write-through |
| req_valid | input | 1 | Request strobe |
| req_alloc | input | 1 | 1 = allocate, 0 = lookup |
| req_va | input | ADDR_W | Virtual address of the request |
| req_pa | input | ADDR_W | Physical address for an allocation |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Hit way or allocated way |
| rsp_data | output | 32 | Addressed word on a hit |
| mem_rd_valid | output | 1 | Refill read request |
| mem_rd_addr | output | ADDR_W | Refill word address |
| mem_rd_data | input | 32 | Refill word |
| mem_rd_ack | input | 1 | Refill word taken this cycle |
| evict_valid | output | 1 | Eviction request |
| evict_set | output | SET_W | Set of the line to evict |
| evict_way | output | WAY_W | Way of the line to evict |
| evict_pa | output | ADDR_W | Stored line-aligned physical address |
| evict_done | input | 1 | Eviction finished |

## Verification
The assertions assume that the memory agent raises `mem_rd_ack` only while `mem_rd_valid` is high. They also assume that `evict_done` comes only while `evict_valid` is high, and that no request is driven while `req_ready` is low. The bench's memory model only answers a pending read, on alternate cycles. Its eviction agent pulses done once per request. Requests are driven only after `req_ready` is seen high.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } cache_state_e;
endpackage

// File: rtl/sa_cache_tags.sv
module sa_cache_tags #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  parameter int LA_W = 28,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  input  logic [LA_W-1:0]  rd_tag,
  input  logic [WAY_W-1:0] vic_way,
  output logic [WAYS-1:0]  hit_vec,
  output logic             vic_valid,
  output logic [LA_W-1:0]  vic_pa,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [LA_W-1:0]  wr_tag,
  input  logic [LA_W-1:0]  wr_pa
);
  logic [LA_W-1:0] tag_q [SETS][WAYS];
  logic [LA_W-1:0] pa_q  [SETS][WAYS];
  logic [WAYS-1:0] vld_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      pa_q[wr_set][wr_way]  <= wr_pa;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
  end

  assign vic_valid = vld_q[rd_set][vic_way];
  assign vic_pa    = pa_q[rd_set][vic_way];
endmodule

// File: rtl/sa_cache_victim.sv
module sa_cache_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] vic_way,
  input  logic             adv_en,
  input  logic [SET_W-1:0] adv_set
);
  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_en) begin
      if (ptr_q[adv_set] == WAY_W'(WAYS - 1)) ptr_q[adv_set] <= '0;
      else                                    ptr_q[adv_set] <= ptr_q[adv_set] + 1'b1;
    end
  end

  assign vic_way = ptr_q[rd_set];
endmodule

// File: rtl/sa_cache_data.sv
module sa_cache_data #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sa_cache_ctrl.sv
module sa_cache_ctrl
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 16,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WORDS  = LINE_BYTES / 4,
  localparam int WORD_W = $clog2(WORDS),
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int DA_W   = SET_W + WAY_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_mode,
  input  logic              req_valid,
  input  logic              req_alloc,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] req_pa,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [31:0]       rsp_data,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  input  logic              mem_rd_ack,
  output logic              evict_valid,
  output logic [SET_W-1:0]  evict_set,
  output logic [WAY_W-1:0]  evict_way,
  output logic [ADDR_W-1:0] evict_pa,
  input  logic              evict_done
);
  cache_state_e state_q;

  logic [SET_W-1:0]  req_set;
  logic [LA_W-1:0]   req_tag;
  logic [WORD_W-1:0] req_word;
  logic              accept;

  logic [SET_W-1:0]  cap_set;
  logic [WAY_W-1:0]  cap_way;
  logic [LA_W-1:0]   cap_tag;
  logic [LA_W-1:0]   cap_pa;
  logic [WORD_W-1:0] cnt_q;

  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_idx;
  logic [WAY_W-1:0]  vic_way;
  logic              vic_valid;
  logic [LA_W-1:0]   vic_pa;

  logic              tag_we;
  logic [SET_W-1:0]  tag_wset;
  logic [WAY_W-1:0]  tag_wway;
  logic [LA_W-1:0]   tag_wtag;
  logic [LA_W-1:0]   tag_wpa;
  logic              fill_last;
  logic              dat_we;
  logic              dat_re;

  assign req_set  = req_va[OFF_W +: SET_W];
  assign req_tag  = req_va[ADDR_W-1:OFF_W];
  assign req_word = req_va[2 +: WORD_W];
  assign accept   = (state_q == ST_IDLE) && req_valid && req_ready;

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_idx = WAY_W'(w);
    end
  end

  assign fill_last = (state_q == ST_FILL) && mem_rd_ack && (cnt_q == WORD_W'(WORDS - 1));
  assign dat_we    = (state_q == ST_FILL) && mem_rd_ack;
  assign dat_re    = accept && !req_alloc;

  always_comb begin
    if (state_q == ST_IDLE) begin
      tag_we   = accept && req_alloc && !wb_mode;
      tag_wset = req_set;
      tag_wway = vic_way;
      tag_wtag = req_tag;
      tag_wpa  = req_pa[ADDR_W-1:OFF_W];
    end else begin
      tag_we   = fill_last;
      tag_wset = cap_set;
      tag_wway = cap_way;
      tag_wtag = cap_tag;
      tag_wpa  = cap_pa;
    end
  end

  sa_cache_tags #(.SETS(SETS), .WAYS(WAYS), .LA_W(LA_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_set(req_set), .rd_tag(req_tag), .vic_way(vic_way),
    .hit_vec(hit_vec), .vic_valid(vic_valid), .vic_pa(vic_pa),
    .wr_en(tag_we), .wr_set(tag_wset), .wr_way(tag_wway),
    .wr_tag(tag_wtag), .wr_pa(tag_wpa)
  );

  sa_cache_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst(rst),
    .rd_set(req_set), .vic_way(vic_way),
    .adv_en(accept && req_alloc), .adv_set(req_set)
  );

  sa_cache_data #(.DEPTH(SETS * WAYS * WORDS)) u_data (
    .clk(clk),
    .wr_en(dat_we), .wr_addr(DA_W'({cap_set, cap_way, cnt_q})), .wr_data(mem_rd_data),
    .rd_en(dat_re), .rd_addr(DA_W'({req_set, hit_idx, req_word})), .rd_data(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      req_ready    <= 1'b1;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      evict_valid  <= 1'b0;
      evict_set    <= '0;
      evict_way    <= '0;
      evict_pa     <= '0;
      cap_set      <= '0;
      cap_way      <= '0;
      cap_tag      <= '0;
      cap_pa       <= '0;
      cnt_q        <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!req_alloc) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= |hit_vec;
              rsp_way   <= hit_idx;
            end else if (!wb_mode) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b0;
              rsp_way   <= vic_way;
            end else begin
              req_ready <= 1'b0;
              cap_set   <= req_set;
              cap_way   <= vic_way;
              cap_tag   <= req_tag;
              cap_pa    <= req_pa[ADDR_W-1:OFF_W];
              cnt_q     <= '0;
              if (vic_valid) begin
                state_q     <= ST_EVICT;
                evict_valid <= 1'b1;
                evict_set   <= req_set;
                evict_way   <= vic_way;
                evict_pa    <= {vic_pa, OFF_W'(0)};
              end else begin
                state_q      <= ST_FILL;
                mem_rd_valid <= 1'b1;
                mem_rd_addr  <= {req_pa[ADDR_W-1:OFF_W], OFF_W'(0)};
              end
            end
          end
        end
        ST_EVICT: begin
          if (evict_done) begin
            evict_valid  <= 1'b0;
            state_q      <= ST_FILL;
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= {cap_pa, OFF_W'(0)};
          end
        end
        ST_FILL: begin
          if (mem_rd_ack) begin
            if (fill_last) begin
              mem_rd_valid <= 1'b0;
              state_q      <= ST_IDLE;
              req_ready    <= 1'b1;
              rsp_valid    <= 1'b1;
              rsp_hit      <= 1'b0;
              rsp_way      <= cap_way;
            end else begin
              cnt_q       <= cnt_q + 1'b1;
              mem_rd_addr <= mem_rd_addr + ADDR_W'(4);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_cache_ctrl_chk.sv
module sa_cache_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_mode,
  input logic              req_valid,
  input logic              req_alloc,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              evict_valid,
  input logic              evict_done
);
  assert_rsp_cause_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rd_valid && mem_rd_ack)));

  assert_evict_no_read_R4: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> !mem_rd_valid);

  assert_evict_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && !evict_done) |=> evict_valid);

  assert_fill_step_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && $past(mem_rd_valid && mem_rd_ack))
      |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(4)));

  assert_fill_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && $past(mem_rd_valid && !mem_rd_ack)) |-> $stable(mem_rd_addr));

  assert_wt_no_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_alloc && !wb_mode)
      |=> (!mem_rd_valid && !evict_valid && req_ready));

  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !mem_rd_valid && !evict_valid));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid || evict_valid) |-> !req_ready);
endmodule

bind sa_cache_ctrl sa_cache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wb_mode(wb_mode), .req_valid(req_valid),
  .req_alloc(req_alloc), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
  .evict_valid(evict_valid), .evict_done(evict_done)
);

// File: tb/sa_cache_ctrl_tb.sv
`timescale 1ns/1ps
module sa_cache_ctrl_tb;
  localparam int ADDR_W = 32;
  localparam int WAY_W  = 1;
  localparam int SET_W  = 2;
  localparam logic [31:0] PA_OFS = 32'h1000_0000;
  localparam logic [31:0] DMASK  = 32'h5A5A_0000;

  typedef struct packed {
    logic        alloc;
    logic        wb;
    logic [31:0] va;
    logic        hit;
    logic        way;
    logic        dchk;
    logic [1:0]  nev;
    logic [31:0] evpa;
    logic [2:0]  nrd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 3'd0},
    '{1'b1, 1'b1, 32'h104, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 3'd4},
    '{1'b0, 1'b0, 32'h108, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0, 3'd0},
    '{1'b1, 1'b1, 32'h200, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 3'd4},
    '{1'b0, 1'b0, 32'h20C, 1'b1, 1'b1, 1'b1, 2'd0, 32'h0, 3'd0},
    '{1'b1, 1'b1, 32'h300, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1000_0100, 3'd4},
    '{1'b0, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 3'd0},
    '{1'b0, 1'b0, 32'h304, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0, 3'd0},
    '{1'b1, 1'b1, 32'h110, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 3'd4},
    '{1'b0, 1'b0, 32'h114, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0, 3'd0},
    '{1'b1, 1'b0, 32'h400, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 3'd0},
    '{1'b0, 1'b0, 32'h400, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0, 3'd0},
    '{1'b0, 1'b0, 32'h200, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 3'd0},
    '{1'b0, 1'b0, 32'h30C, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0, 3'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wb_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_alloc = 1'b0;
  logic [ADDR_W-1:0] req_va = '0;
  logic [ADDR_W-1:0] req_pa = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [WAY_W-1:0] rsp_way;
  logic [31:0] rsp_data;
  logic mem_rd_valid;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic mem_rd_ack = 1'b0;
  logic evict_valid;
  logic [SET_W-1:0] evict_set;
  logic [WAY_W-1:0] evict_way;
  logic [ADDR_W-1:0] evict_pa;
  logic evict_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int ev_cnt = 0;
  int ord_err = 0;
  logic [31:0] first_addr = '0;
  logic [31:0] prev_addr = '0;
  logic [31:0] last_evpa = '0;
  logic tgl = 1'b0;
  logic busy_seen = 1'b0;
  logic got_hit = 1'b0;
  logic [31:0] got_way = '0;
  logic [31:0] got_data = '0;

  always #4 clk = ~clk;

  sa_cache_ctrl u_dut (
    .clk(clk), .rst(rst), .wb_mode(wb_mode), .req_valid(req_valid),
    .req_alloc(req_alloc), .req_va(req_va), .req_pa(req_pa), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_ack(mem_rd_ack), .evict_valid(evict_valid), .evict_set(evict_set),
    .evict_way(evict_way), .evict_pa(evict_pa), .evict_done(evict_done)
  );

  // memory and eviction agents, driven away from the active edge
  always @(negedge clk) begin
    tgl <= ~tgl;
    if (mem_rd_valid && tgl) begin
      mem_rd_ack  <= 1'b1;
      mem_rd_data <= mem_rd_addr ^ DMASK;
      if (rd_cnt == 0) first_addr = mem_rd_addr;
      else if (mem_rd_addr != prev_addr + 32'd4) ord_err = ord_err + 1;
      prev_addr = mem_rd_addr;
      rd_cnt = rd_cnt + 1;
    end else begin
      mem_rd_ack <= 1'b0;
    end
    if (evict_valid && !evict_done) begin
      evict_done <= 1'b1;
      last_evpa = evict_pa;
      ev_cnt = ev_cnt + 1;
    end else begin
      evict_done <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic alloc, input logic wb, input logic [31:0] va);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0; ev_cnt = 0; ord_err = 0;
    req_valid = 1'b1; req_alloc = alloc; wb_mode = wb;
    req_va = va; req_pa = va + PA_OFS;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    while (!rsp_valid) @(negedge clk);
    got_hit = rsp_hit;
    got_way = 32'(rsp_way);
    got_data = rsp_data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R7 ready after reset", 32'(req_ready), 32'd1);
    chk("R7 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R7 mem_rd_valid after reset", 32'(mem_rd_valid), 32'd0);
    chk("R7 evict_valid after reset", 32'(evict_valid), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog expired actual=busy expected=idle");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      do_req(v.alloc, v.wb, v.va);
      if (!v.alloc) begin
        chk(v.hit ? "R1 lookup hit" : "R2 lookup miss", 32'(got_hit), 32'(v.hit));
        if (v.hit) chk("R1 hit way", got_way, 32'(v.way));
        if (v.dchk) chk("R5 hit data", got_data, ((v.va & 32'hFFFF_FFFC) + PA_OFS) ^ DMASK);
      end else begin
        chk("R3 alloc rsp_hit", 32'(got_hit), 32'd0);
        chk("R3 victim way", got_way, 32'(v.way));
        chk("R4 eviction count", 32'(ev_cnt), 32'(v.nev));
        if (v.nev != 0) chk("R4 evict_pa", last_evpa, v.evpa);
        chk(v.wb ? "R5 refill reads" : "R6 no reads", 32'(rd_cnt), 32'(v.nrd));
        if (v.wb) begin
          chk("R5 first refill addr", first_addr, (v.va & 32'hFFFF_FFF0) + PA_OFS);
          chk("R5 refill order", 32'(ord_err), 32'd0);
          chk("R8 busy after accept", 32'(busy_seen), 32'd1);
        end else begin
          chk("R6 ready stays high", 32'(req_ready), 32'd1);
          chk("R6 no busy", 32'(busy_seen), 32'd0);
        end
      end
    end

    // reset mid-run clears tags and pointers
    do_reset();
    do_req(1'b0, 1'b0, 32'h304);
    chk("R7 tags invalid after reset", 32'(got_hit), 32'd0);
    do_req(1'b1, 1'b1, 32'h500);
    chk("R7 pointer back to way 0", got_way, 32'd0);
    chk("R7 no eviction after reset", 32'(ev_cnt), 32'd0);
    do_req(1'b0, 1'b0, 32'h508);
    chk("R1 hit after fill", 32'(got_hit), 32'd1);
    chk("R5 data after fill", got_data, (32'h508 + PA_OFS) ^ DMASK);

    // other set untouched by set 0 allocations
    do_req(1'b1, 1'b0, 32'h120);
    chk("R3 set 2 pointer independent", got_way, 32'd0);
    do_req(1'b1, 1'b0, 32'h220);
    chk("R3 set 2 pointer advances", got_way, 32'd1);
    do_req(1'b1, 1'b0, 32'h320);
    chk("R3 set 2 pointer wraps", got_way, 32'd0);
    do_req(1'b0, 1'b0, 32'h120);
    chk("R2 replaced line misses", 32'(got_hit), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule